// File: doc/BRIEF.md
# Software-Generated Interrupt Pending Store

This block keeps the pending state of software-generated interrupts for an interrupt controller serving up to eight CPUs with sixteen interrupt IDs each. Each CPU can raise one of these interrupts by writing a single 32-bit generation word. That word names an interrupt ID, a list of target CPUs and a filter that decides how the list is used. The block turns the one write into updates of every selected CPU's state.

For every CPU and every ID, the block records which requesting CPUs raised the interrupt, as a source mask with one bit per CPU, plus a pending latch. Each CPU reaches its own sixteen source masks through two banked windows. A write to the OR window sets mask bits; a write to the AND-NOT window clears them. A read from either window returns the masks. Accesses may be single bytes or 32-bit words. The pending latches of all CPUs are driven out as one flat vector for the delivery logic downstream.

Top module: `sgi_unit`

## Requirements
- R1: After reset every source mask and every pending latch is zero, so `pend_out` reads all zeros. Bit `c*16+id` of `pend_out` is the latch of CPU c, ID id.
- R2: A write to region 0 (`req_addr[5:4]`=00) is a generation word. ID is bits 3:0, target list is bits 23:16, filter is bits 25:24. Filter 0 sets the pending latch of that ID on each listed CPU. The result shows on `pend_out` one clock after the write.
- R3: Filter 1 targets every online CPU except the requester.
- R4: Filter 2 targets only the requester.
- R5: Filter 3 is reserved: the whole write changes no state.
- R6: CPUs numbered at or above `online_cnt` are never updated by a generation write, whatever the target list or filter.
- R7: A read of region 0 returns zero.
- R8: For each CPU targeted by a generation write, the source-mask bit equal to the requester's CPU number is set.
- R9: A write to the OR window (region 2, `req_addr[5:4]`=10) ORs the written byte into the addressed mask of the requester's own bank. The pending latch is set only if the resulting mask is nonzero.
- R10: A write to the AND-NOT window (region 1, `req_addr[5:4]`=01) clears the written bits in the addressed mask. When the mask becomes zero the pending latch clears; otherwise it stays set.
- R11: A byte access (`req_word`=0) addresses ID `req_addr[3:0]` using byte 0 of the data. A word access (`req_word`=1) addresses the four IDs `{req_addr[3:2],i}`, i=0..3, with byte i in bits 8i+7:8i. Reads of either window return the masks packed in the same way, with unused bits zero.
- R12: Window accesses reach only the requester's own bank; no other CPU's state changes.
- R13: Without an accepted write (`req_valid` and `req_write`), `pend_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| online_cnt | input | 4 | Number of online CPUs, 1..NCPU, static while out of reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for 32-bit access, 0 for byte access |
| req_cpu | input | 3 | Number of the requesting CPU |
| req_addr | input | 6 | Region in bits 5:4, byte offset in bits 3:0 |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pend_out | output | NCPU*16 | Pending latches, CPU-major |

## Verification
Generation words are issued with each of the four filters, from several requesters, with target lists that are sparse, full and empty. This separates a list-driven target set from the all-but-self and self-only variants, and shows the reserved filter to be inert. A second reset with only three CPUs online repeats full-list and all-but-self writes, so that target bits for offline CPUs can be told apart from real updates. Window traffic mixes byte and word accesses, zero and nonzero OR data, and partial and complete clears. This exposes lane ordering, the pending rule that depends on whether the mask is zero, and any leak into another CPU's bank.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int NUM_ID   = 16;
   localparam int ID_W     = 4;
   localparam int DATA_W   = 32;
   localparam int BYTE_W   = 8;
   localparam int LANES    = DATA_W / BYTE_W;
   localparam int GEN_LIST_LSB = 16;
   localparam int GEN_FLT_LSB  = 24;

   typedef enum logic [1:0] {
      RGN_GEN  = 2'b00,
      RGN_CLR  = 2'b01,
      RGN_SET  = 2'b10,
      RGN_NONE = 2'b11
   } rgn_e;

   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_RSVD   = 2'd3
   } flt_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
   import sgi_pkg::*;
#(
   parameter int NCPU = 8
) (
   input  logic [1:0]      flt_i,
   input  logic [7:0]      list_i,
   input  logic [2:0]      req_cpu_i,
   input  logic [3:0]      online_cnt_i,
   output logic [NCPU-1:0] tgt_o
);
   logic [NCPU-1:0] online_msk;
   logic [NCPU-1:0] self_msk;
   logic [NCPU-1:0] raw;

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign online_msk[c] = (4'(c) < online_cnt_i);
      assign self_msk[c]   = (req_cpu_i == 3'(c));
   end

   always_comb begin
      unique case (flt_e'(flt_i))
         FLT_LIST:   raw = list_i[NCPU-1:0];
         FLT_OTHERS: raw = ~self_msk;
         FLT_SELF:   raw = self_msk;
         default:    raw = '0;
      endcase
      tgt_o = raw & online_msk;
   end
endmodule

// File: rtl/sgi_bank.sv
module sgi_bank
   import sgi_pkg::*;
#(
   parameter int NCPU = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     gen_hit_i,
   input  logic [ID_W-1:0]          gen_id_i,
   input  logic [NCPU-1:0]          gen_src_i,
   input  logic                     win_en_i,
   input  logic                     win_set_i,
   input  logic [NUM_ID-1:0]        id_en_i,
   input  logic [NUM_ID*BYTE_W-1:0] id_data_i,
   output logic [NUM_ID*NCPU-1:0]   mask_o,
   output logic [NUM_ID-1:0]        pend_o
);
   for (genvar i = 0; i < NUM_ID; i++) begin : g_id
      logic [NCPU-1:0] msk_q;
      logic [NCPU-1:0] msk_nxt;
      logic [NCPU-1:0] wbits;
      logic            pnd_q;

      assign wbits = id_data_i[i*BYTE_W +: NCPU];

      always_comb begin
         if (win_set_i) msk_nxt = msk_q | wbits;
         else           msk_nxt = msk_q & ~wbits;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            msk_q <= '0;
            pnd_q <= 1'b0;
         end else if (gen_hit_i && (gen_id_i == ID_W'(i))) begin
            msk_q <= msk_q | gen_src_i;
            pnd_q <= 1'b1;
         end else if (win_en_i && id_en_i[i]) begin
            msk_q <= msk_nxt;
            if (win_set_i) pnd_q <= pnd_q | (|msk_nxt);
            else           pnd_q <= pnd_q & (|msk_nxt);
         end
      end

      assign mask_o[i*NCPU +: NCPU] = msk_q;
      assign pend_o[i]              = pnd_q;
   end
endmodule

// File: rtl/sgi_unit.sv
module sgi_unit
   import sgi_pkg::*;
#(
   parameter int NCPU = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [3:0]             online_cnt,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic                   req_word,
   input  logic [2:0]             req_cpu,
   input  logic [5:0]             req_addr,
   input  logic [31:0]            req_wdata,
   output logic [31:0]            req_rdata,
   output logic [NCPU*NUM_ID-1:0] pend_out
);
   localparam int MASK_BITS = NUM_ID * NCPU;

   if (NCPU < 1 || NCPU > BYTE_W) begin : g_bad_ncpu
      $error("sgi_unit: NCPU must lie in 1..8");
   end

   rgn_e                     rgn;
   logic                     acc_wr;
   logic                     gen_wr;
   logic                     win_wr;
   logic                     win_rd;
   logic [NCPU-1:0]          tgt;
   logic [NCPU-1:0]          src;
   logic [NUM_ID-1:0]        id_en;
   logic [NUM_ID*BYTE_W-1:0] id_data;
   logic [MASK_BITS-1:0]     bank_mask [NCPU];
   logic [MASK_BITS-1:0]     sel_mask;

   assign rgn    = rgn_e'(req_addr[5:4]);
   assign acc_wr = req_valid && req_write;
   assign gen_wr = acc_wr && (rgn == RGN_GEN);
   assign win_wr = acc_wr && ((rgn == RGN_CLR) || (rgn == RGN_SET));
   assign win_rd = req_valid && !req_write && ((rgn == RGN_CLR) || (rgn == RGN_SET));

   sgi_target_decode #(.NCPU(NCPU)) u_dec (
      .flt_i        (req_wdata[GEN_FLT_LSB +: 2]),
      .list_i       (req_wdata[GEN_LIST_LSB +: 8]),
      .req_cpu_i    (req_cpu),
      .online_cnt_i (online_cnt),
      .tgt_o        (tgt)
   );

   for (genvar c = 0; c < NCPU; c++) begin : g_src
      assign src[c] = (req_cpu == 3'(c));
   end

   for (genvar i = 0; i < NUM_ID; i++) begin : g_lane
      localparam logic [ID_W-1:0] IDV = ID_W'(i);
      assign id_en[i] = req_word ? (IDV[ID_W-1:2] == req_addr[3:2])
                                 : (IDV == req_addr[3:0]);
      assign id_data[i*BYTE_W +: BYTE_W] =
         req_word ? req_wdata[(i % LANES)*BYTE_W +: BYTE_W] : req_wdata[BYTE_W-1:0];
   end

   for (genvar c = 0; c < NCPU; c++) begin : g_bank
      sgi_bank #(.NCPU(NCPU)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .gen_hit_i (gen_wr && tgt[c]),
         .gen_id_i  (req_wdata[ID_W-1:0]),
         .gen_src_i (src),
         .win_en_i  (win_wr && src[c]),
         .win_set_i (rgn == RGN_SET),
         .id_en_i   (id_en),
         .id_data_i (id_data),
         .mask_o    (bank_mask[c]),
         .pend_o    (pend_out[c*NUM_ID +: NUM_ID])
      );
   end

   always_comb begin
      sel_mask = '0;
      for (int c = 0; c < NCPU; c++) begin
         if (src[c]) sel_mask = bank_mask[c];
      end
   end

   always_comb begin
      req_rdata = '0;
      if (win_rd) begin
         if (req_word) begin
            for (int b = 0; b < LANES; b++) begin
               req_rdata[b*BYTE_W +: NCPU] =
                  sel_mask[({req_addr[3:2], 2'b00} + b) * NCPU +: NCPU];
            end
         end else begin
            req_rdata[NCPU-1:0] = sel_mask[req_addr[3:0] * NCPU +: NCPU];
         end
      end
   end
endmodule

// File: rtl/sgi_unit_chk.sv
module sgi_unit_chk
   import sgi_pkg::*;
#(
   parameter int NCPU = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [3:0]             online_cnt,
   input logic                   req_valid,
   input logic                   req_write,
   input logic [2:0]             req_cpu,
   input logic [5:0]             req_addr,
   input logic [31:0]            req_wdata,
   input logic [31:0]            req_rdata,
   input logic [NCPU*NUM_ID-1:0] pend_out
);
   logic gen_wr;
   logic self_q;
   logic [$clog2(NCPU*NUM_ID+1)-1:0] self_idx_q;

   assign gen_wr = req_valid && req_write && (req_addr[5:4] == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         self_q     <= 1'b0;
         self_idx_q <= '0;
      end else begin
         self_q     <= gen_wr && (req_wdata[25:24] == 2'd2) &&
                       (4'(req_cpu) < online_cnt) && (32'(req_cpu) < NCPU);
         self_idx_q <= $bits(self_idx_q)'(32'(req_cpu) * NUM_ID + 32'(req_wdata[3:0]));
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pend_out == '0));

   assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid && req_write) |-> $stable(pend_out));

   assert_rsvd_inert_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gen_wr && (req_wdata[25:24] == 2'd3)) |-> $stable(pend_out));

   assert_gen_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && (req_addr[5:4] == 2'b00)) |-> (req_rdata == '0));

   assert_self_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      self_q |-> pend_out[self_idx_q]);

   for (genvar c = 0; c < NCPU; c++) begin : g_off
      assert_offline_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(gen_wr) && (4'(c) >= online_cnt)) |-> $stable(pend_out[c*NUM_ID +: NUM_ID]));
   end
endmodule

bind sgi_unit sgi_unit_chk #(.NCPU(NCPU)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .online_cnt (online_cnt),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_cpu    (req_cpu),
   .req_addr   (req_addr),
   .req_wdata  (req_wdata),
   .req_rdata  (req_rdata),
   .pend_out   (pend_out)
);

// File: tb/sim_sgi_unit.sv
`timescale 1ns/1ps
module sim_sgi_unit;
   localparam int NC = 8;
   localparam int NI = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      online_cnt = 4'd8;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic            req_word = 1'b0;
   logic [2:0]      req_cpu = '0;
   logic [5:0]      req_addr = '0;
   logic [31:0]     req_wdata = '0;
   logic [31:0]     req_rdata;
   logic [NC*NI-1:0] pend_out;

   int    checks = 0;
   int    failures = 0;
   bit    done = 0;
   string tag = "R1";

   logic [7:0] m_msk [NC][NI];
   bit         m_pnd [NC][NI];

   always #4 clk = ~clk;

   sgi_unit #(.NCPU(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .online_cnt(online_cnt), .req_valid(req_valid),
      .req_write(req_write), .req_word(req_word), .req_cpu(req_cpu),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
      .pend_out(pend_out)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NC; c++)
            for (int i = 0; i < NI; i++) begin m_msk[c][i] = 8'h00; m_pnd[c][i] = 0; end
      end else if (req_valid && req_write) begin
         int rg;
         rg = int'(req_addr[5:4]);
         if (rg == 0) begin
            int md, id;
            logic [7:0] t;
            md = int'(req_wdata[25:24]);
            id = int'(req_wdata[3:0]);
            t = 8'h00;
            if (md == 0) t = req_wdata[23:16];
            else if (md == 1) t = ~(8'h01 << req_cpu);
            else if (md == 2) t = 8'h01 << req_cpu;
            for (int c = 0; c < NC; c++)
               if (t[c] && c < int'(online_cnt)) begin
                  m_msk[c][id] = m_msk[c][id] | (8'h01 << req_cpu);
                  m_pnd[c][id] = 1;
               end
         end else if (rg == 1 || rg == 2) begin
            int cp;
            cp = int'(req_cpu);
            for (int k = 0; k < NI; k++) begin
               bit en;
               logic [7:0] b;
               en = req_word ? ((k / 4) == int'(req_addr[3:2])) : (k == int'(req_addr[3:0]));
               b  = req_word ? req_wdata[(k % 4)*8 +: 8] : req_wdata[7:0];
               if (en) begin
                  if (rg == 2) begin
                     m_msk[cp][k] = m_msk[cp][k] | b;
                     if (m_msk[cp][k] != 0) m_pnd[cp][k] = 1;
                  end else begin
                     m_msk[cp][k] = m_msk[cp][k] & ~b;
                     if (m_msk[cp][k] == 0) m_pnd[cp][k] = 0;
                  end
               end
            end
         end
      end
   end

   function automatic logic [31:0] model_rd();
      logic [31:0] r;
      int rg;
      r = '0;
      rg = int'(req_addr[5:4]);
      if (rg == 1 || rg == 2) begin
         if (req_word) begin
            for (int b = 0; b < 4; b++)
               r[b*8 +: 8] = m_msk[req_cpu][int'(req_addr[3:2])*4 + b];
         end else r[7:0] = m_msk[req_cpu][req_addr[3:0]];
      end
      return r;
   endfunction

   task automatic chk_pend();
      logic [NC*NI-1:0] e;
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < NI; i++) e[c*NI + i] = m_pnd[c][i];
      checks++;
      if (pend_out !== e) begin
         failures++;
         $display("FAIL %s pend_out actual=%h expected=%h", tag, pend_out, e);
      end
   endtask

   task automatic chk_rd();
      logic [31:0] e;
      e = model_rd();
      checks++;
      if (req_rdata !== e) begin
         failures++;
         $display("FAIL %s req_rdata actual=%h expected=%h", tag, req_rdata, e);
      end
   endtask

   task automatic op(input bit v, input bit w, input bit wd, input int cpu,
                     input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      chk_pend();
      req_valid = v; req_write = w; req_word = wd;
      req_cpu = 3'(cpu); req_addr = a; req_wdata = d;
      #1;
      if (v && !w) chk_rd();
   endtask

   task automatic idle();
      op(0, 0, 0, 0, 6'h00, 32'h0);
   endtask

   task automatic gen(input int cpu, input int md, input logic [7:0] lst, input int id);
      op(1, 1, 0, cpu, 6'h00, {6'b0, 2'(md), lst, 12'h000, 4'(id)});
      idle();
   endtask

   task automatic do_reset(input int onl);
      @(negedge clk);
      rst_n = 1'b0; online_cnt = 4'(onl);
      req_valid = 0; req_write = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset(8);
      tag = "R1"; idle(); idle();
      // filter 0, sparse list: CPUs 0,4,7 at ID 5 from CPU 2
      tag = "R2"; gen(2, 0, 8'h91, 5);
      tag = "R8"; op(1, 0, 0, 0, 6'h25, 32'h0); op(1, 0, 0, 7, 6'h15, 32'h0);
      tag = "R3"; gen(3, 1, 8'h00, 9);
      tag = "R4"; gen(6, 2, 8'hFF, 0);
      tag = "R5"; gen(1, 3, 8'hFF, 7);
      tag = "R2"; gen(0, 0, 8'h00, 3);
      tag = "R7"; op(1, 0, 1, 1, 6'h00, 32'h0); op(1, 0, 0, 1, 6'h03, 32'h0);
      tag = "R9"; op(1, 1, 0, 1, 6'h2C, 32'h0000FF00); idle();
      op(1, 1, 0, 1, 6'h2C, 32'h00000030); idle();
      tag = "R11"; op(1, 1, 1, 5, 6'h24, 32'h0A000301); idle();
      op(1, 0, 1, 5, 6'h14, 32'h0); op(1, 0, 0, 5, 6'h27, 32'h0);
      tag = "R10"; op(1, 1, 0, 5, 6'h15, 32'h00000001); idle();
      op(1, 1, 0, 5, 6'h15, 32'h00000002); idle();
      op(1, 1, 1, 0, 6'h14, 32'hFFFFFFFF); idle();
      tag = "R12"; op(1, 1, 1, 4, 6'h2C, 32'h80402010); idle();
      op(1, 0, 1, 3, 6'h2C, 32'h0);
      tag = "R13"; op(0, 1, 1, 2, 6'h2C, 32'hFFFFFFFF); idle();
      tag = "R6"; do_reset(3); idle();
      gen(0, 0, 8'hFF, 1);
      gen(4, 0, 8'hF8, 2);
      tag = "R3"; gen(1, 1, 8'h00, 2);
      tag = "R8"; op(1, 0, 1, 2, 6'h20, 32'h0);
      idle(); idle();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule